// File: doc/BRIEF.md
# Vector Floating-Point Exception Status Accumulator

This block keeps the floating-point control and status word of a 128-bit SIMD floating-point unit. It does not compute anything. Each lane's arithmetic unit reports its five IEEE exception flags, and this block takes those reports one lane at a time. It folds each report into the status word and decides after every lane whether the instruction must trap.

The status word has three five-bit fields:

- an enable field at bits 4:0, latched when an instruction opens;
- a sticky field at bits 20:16;
- a cause field at bits 28:24.

Inside each field the flags sit in this order: invalid is bit 4, divide-by-zero bit 3, overflow bit 2, underflow bit 1 and inexact bit 0.

An instruction opens with a start pulse. The pulse carries four things:

- whether the operation computes;
- whether the lanes are single precision (four lanes) or double precision (two lanes);
- a five-bit mask of flags to drop, for example inexact for the log-base-2 operation;
- the enable field.

Lane reports then arrive on a valid/ready stream. The producer holds `lane_valid` and `lane_flags` steady until `lane_ready` is high at a clock edge. `lane_ready` is low in four cases:

- no instruction is open;
- the trap request is set;
- all of the instruction's lanes have been taken;
- a start pulse is present in that cycle.

An operation that does not compute, such as classify or a register move, sends a start pulse with `insn_computes` low and no lanes.

Top module: `fpx_status_acc`

## Requirements
- R1: After reset, `csr_o` is zero, `trap_o` and `done_o` are low, and `lane_ready` is low.
- R2: A start pulse with `insn_computes` high clears the cause field (bits 28:24) and the trap request, and latches `insn_enables` into bits 4:0. It opens 4 lanes when `insn_double` is low and 2 lanes when it is high. The sticky field (bits 20:16) is kept. The effects show in the cycle after the pulse.
- R3: Each accepted lane ORs its effective flags into the cause field in the cycle after the handshake. Cause bits from earlier lanes of the same instruction are kept.
- R4: If an accepted lane's effective flags share a set bit with the enable field, `trap_o` rises in the next cycle, and that lane leaves the sticky field unchanged. The test uses only that lane's own flags.
- R5: If no effective flag of an accepted lane is enabled, the lane's effective flags are ORed into the sticky field. Sticky bits are never cleared except by reset.
- R6: The effective flags are `lane_flags & ~mask`, where mask is `insn_mask` latched at the computing start. Masked flags reach neither the cause field, nor the sticky field, nor the trap test.
- R7: Once set, `trap_o` stays high until the next computing start pulse. No further lane of that instruction is accepted, so `csr_o` does not change even when `lane_valid` is held high.
- R8: `done_o` is high for exactly one cycle, the cycle after the instruction's final lane is accepted or after its trapping lane is accepted, whichever comes first.
- R9: A start pulse with `insn_computes` low leaves `csr_o`, `trap_o` and `lane_ready` unchanged and opens no lanes.
- R10: `lane_ready` equals (instruction open) and (trap low) and (`insn_start` low). A lane presented while `lane_ready` is low is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | One-cycle pulse that opens an instruction |
| insn_computes | input | 1 | With `insn_start`: high for an arithmetic operation, low for classify or a move |
| insn_double | input | 1 | With `insn_start`: high for two 64-bit lanes, low for four 32-bit lanes |
| insn_mask | input | 5 | With `insn_start`: flags to drop for this instruction |
| insn_enables | input | 5 | With `insn_start`: trap enables for this instruction |
| lane_valid | input | 1 | A lane flag report is presented |
| lane_ready | output | 1 | The block accepts the presented report at this edge |
| lane_flags | input | 5 | Raw IEEE flags of the presented lane |
| csr_o | output | 32 | Status word: enables at 4:0, sticky at 20:16, cause at 28:24, all other bits zero |
| trap_o | output | 1 | Floating-point exception request |
| done_o | output | 1 | One-cycle pulse when the instruction closes |

## Verification
Two things can fall on one accepted lane: the trap decision and the instruction's close. When the final lane carries an enabled flag, `trap_o` and `done_o` must rise in the same cycle, the cause field must take the lane's flags, and the sticky field must stay put. The bench provokes this directly with a trap on the fourth single-precision lane and on the second double-precision lane. It also provokes it at random, with sparse enables over random flags. A reference model in the bench tracks the open lane count, cause, sticky and trap, and each cycle it judges `lane_ready`, both pulses and every field against that model.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;
  localparam int FLAG_W  = 5;
  localparam int CSR_W   = 32;
  localparam int ENA_LSB = 0;
  localparam int STK_LSB = 16;
  localparam int CAU_LSB = 24;

  typedef logic [FLAG_W-1:0] fpflag_t;
endpackage

// File: rtl/fpx_lane_seq.sv
module fpx_lane_seq #(
  parameter int VEC_W = 128,
  parameter int SP_W  = 32,
  parameter int DP_W  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic dbl_i,
  input  logic accept_i,
  input  logic trap_hit_i,
  output logic active_o,
  output logic done_o
);
  localparam int SP_LANES = VEC_W / SP_W;
  localparam int DP_LANES = VEC_W / DP_W;
  localparam int MAX_LANES = (SP_LANES > DP_LANES) ? SP_LANES : DP_LANES;
  localparam int CNT_W = $clog2(MAX_LANES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             closing;

  assign cnt_inc = cnt_q + CNT_W'(1);
  // the instruction closes on its final lane or on the lane that traps
  assign closing = accept_i && ((cnt_inc == lim_q) || trap_hit_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else begin
      done_o <= 1'b0;
      if (open_i) begin
        active_o <= 1'b1;
        cnt_q    <= '0;
        lim_q    <= dbl_i ? CNT_W'(DP_LANES) : CNT_W'(SP_LANES);
      end else if (accept_i) begin
        cnt_q <= cnt_inc;
        if (closing) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fpx_flag_fold.sv
module fpx_flag_fold
  import fpacc_pkg::*;
(
  input  fpflag_t raw_i,
  input  fpflag_t mask_i,
  input  fpflag_t en_i,
  input  fpflag_t cause_i,
  input  fpflag_t sticky_i,
  output fpflag_t cause_o,
  output fpflag_t sticky_o,
  output logic    trap_hit_o
);
  fpflag_t eff;
  fpflag_t hit;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    assign eff[b] = raw_i[b] & ~mask_i[b];
    assign hit[b] = eff[b] & en_i[b];
  end

  assign trap_hit_o = |hit;
  assign cause_o    = cause_i | eff;
  assign sticky_o   = trap_hit_o ? sticky_i : (sticky_i | eff);
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  fpflag_t          en_in,
  input  fpflag_t          mask_in,
  input  logic             accept_i,
  input  fpflag_t          cause_nxt,
  input  fpflag_t          sticky_nxt,
  input  logic             trap_hit_i,
  output fpflag_t          en_q,
  output fpflag_t          mask_q,
  output fpflag_t          cause_q,
  output fpflag_t          sticky_q,
  output logic             trap_q,
  output logic [CSR_W-1:0] csr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      mask_q   <= '0;
      cause_q  <= '0;
      sticky_q <= '0;
      trap_q   <= 1'b0;
    end else if (open_i) begin
      en_q    <= en_in;
      mask_q  <= mask_in;
      cause_q <= '0;
      trap_q  <= 1'b0;
    end else if (accept_i) begin
      cause_q  <= cause_nxt;
      sticky_q <= sticky_nxt;
      if (trap_hit_i) trap_q <= 1'b1;
    end
  end

  always_comb begin
    csr_o = '0;
    csr_o[ENA_LSB +: FLAG_W] = en_q;
    csr_o[STK_LSB +: FLAG_W] = sticky_q;
    csr_o[CAU_LSB +: FLAG_W] = cause_q;
  end
endmodule

// File: rtl/fpx_status_acc.sv
module fpx_status_acc
  import fpacc_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SP_W  = 32,
  parameter int DP_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_start,
  input  logic              insn_computes,
  input  logic              insn_double,
  input  logic [FLAG_W-1:0] insn_mask,
  input  logic [FLAG_W-1:0] insn_enables,
  input  logic              lane_valid,
  output logic              lane_ready,
  input  logic [FLAG_W-1:0] lane_flags,
  output logic [CSR_W-1:0]  csr_o,
  output logic              trap_o,
  output logic              done_o
);
  logic    open_w;
  logic    accept_w;
  logic    active_w;
  logic    trap_hit_w;
  fpflag_t en_w, mask_w, cause_w, sticky_w;
  fpflag_t cause_nxt_w, sticky_nxt_w;

  assign open_w     = insn_start & insn_computes;
  assign lane_ready = active_w & ~trap_o & ~insn_start;
  assign accept_w   = lane_valid & lane_ready;

  fpx_lane_seq #(.VEC_W(VEC_W), .SP_W(SP_W), .DP_W(DP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (open_w),
    .dbl_i      (insn_double),
    .accept_i   (accept_w),
    .trap_hit_i (trap_hit_w),
    .active_o   (active_w),
    .done_o     (done_o)
  );

  fpx_flag_fold u_fold (
    .raw_i      (lane_flags),
    .mask_i     (mask_w),
    .en_i       (en_w),
    .cause_i    (cause_w),
    .sticky_i   (sticky_w),
    .cause_o    (cause_nxt_w),
    .sticky_o   (sticky_nxt_w),
    .trap_hit_o (trap_hit_w)
  );

  fpx_status_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (open_w),
    .en_in      (insn_enables),
    .mask_in    (insn_mask),
    .accept_i   (accept_w),
    .cause_nxt  (cause_nxt_w),
    .sticky_nxt (sticky_nxt_w),
    .trap_hit_i (trap_hit_w),
    .en_q       (en_w),
    .mask_q     (mask_w),
    .cause_q    (cause_w),
    .sticky_q   (sticky_w),
    .trap_q     (trap_o),
    .csr_o      (csr_o)
  );
endmodule

// File: rtl/fpx_status_acc_chk.sv
module fpx_status_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_start,
  input logic        insn_computes,
  input logic        lane_valid,
  input logic        lane_ready,
  input logic [31:0] csr_o,
  input logic        trap_o,
  input logic        done_o
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && insn_computes) |=> (csr_o[28:24] == 5'd0 && !trap_o));

  // R3
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_start && insn_computes) |=>
      ((csr_o[28:24] & $past(csr_o[28:24])) == $past(csr_o[28:24])));

  // R5
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((csr_o[20:16] & $past(csr_o[20:16])) == $past(csr_o[20:16])));

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !(insn_start && insn_computes)) |=> trap_o);

  // R10
  trap_blocks_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !lane_ready);

  // R8
  done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !lane_ready);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(insn_start && insn_computes) && !(lane_valid && lane_ready)) |=> $stable(csr_o));
endmodule

bind fpx_status_acc fpx_status_acc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_start    (insn_start),
  .insn_computes (insn_computes),
  .lane_valid    (lane_valid),
  .lane_ready    (lane_ready),
  .csr_o         (csr_o),
  .trap_o        (trap_o),
  .done_o        (done_o)
);

// File: tb/sim_fpx_status_acc.sv
`timescale 1ns/1ps
module sim_fpx_status_acc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_start, insn_computes, insn_double;
  logic [4:0]  insn_mask, insn_enables;
  logic        lane_valid;
  logic        lane_ready;
  logic [4:0]  lane_flags;
  logic [31:0] csr_o;
  logic        trap_o, done_o;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 1'b0;

  // bench reference state
  logic [4:0] m_en, m_mask, m_cau, m_stk;
  logic       m_trap, m_active, m_done;
  int         m_cnt, m_lim;

  always #2 clk = ~clk;

  fpx_status_acc u0 (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_computes(insn_computes),
    .insn_double(insn_double), .insn_mask(insn_mask), .insn_enables(insn_enables),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_flags(lane_flags),
    .csr_o(csr_o), .trap_o(trap_o), .done_o(done_o)
  );

  function automatic logic [4:0] eff_flags(logic [4:0] raw, logic [4:0] msk);
    return raw & ~msk;
  endfunction

  function automatic logic [31:0] pack_csr(logic [4:0] en, logic [4:0] stk, logic [4:0] cau);
    return {3'b000, cau, 3'b000, stk, 11'd0, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic s, input logic c, input logic d, input logic [4:0] msk,
                      input logic [4:0] en, input logic v, input logic [4:0] f);
    logic       exp_ready;
    logic [4:0] fl;
    insn_start = s; insn_computes = c; insn_double = d;
    insn_mask = msk; insn_enables = en; lane_valid = v; lane_flags = f;
    #1;
    exp_ready = m_active && !m_trap && !s;
    chk("R10 ready", {31'd0, lane_ready}, {31'd0, exp_ready});
    m_done = 1'b0;
    if (s && c) begin
      m_en = en; m_mask = msk; m_cau = 5'd0; m_trap = 1'b0;
      m_active = 1'b1; m_cnt = 0; m_lim = d ? 2 : 4;
    end else if (v && exp_ready) begin
      fl = eff_flags(f, m_mask);
      m_cau = m_cau | fl;
      if ((fl & m_en) != 5'd0) m_trap = 1'b1;
      else m_stk = m_stk | fl;
      m_cnt++;
      if (m_cnt == m_lim || m_trap) begin
        m_active = 1'b0;
        m_done = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3 cause",  {27'd0, csr_o[28:24]}, {27'd0, m_cau});
    chk("R5 sticky", {27'd0, csr_o[20:16]}, {27'd0, m_stk});
    chk("R2 enables", csr_o & 32'he0e0_ffe0 | {27'd0, csr_o[4:0]}, {27'd0, m_en});
    chk("R4 trap",   {31'd0, trap_o}, {31'd0, m_trap});
    chk("R8 done",   {31'd0, done_o}, {31'd0, m_done});
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    insn_start = 0; insn_computes = 0; insn_double = 0;
    insn_mask = 0; insn_enables = 0; lane_valid = 0; lane_flags = 0;
    m_en = 0; m_mask = 0; m_cau = 0; m_stk = 0;
    m_trap = 0; m_active = 0; m_done = 0; m_cnt = 0; m_lim = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csr",   csr_o, 32'd0);
    chk("R1 trap",  {31'd0, trap_o}, 32'd0);
    chk("R1 done",  {31'd0, done_o}, 32'd0);
    chk("R1 ready", {31'd0, lane_ready}, 32'd0);
    rst_n = 1'b1;
    idle();

    // four single lanes, no enables: cause and sticky both gather every flag
    step(1, 1, 0, 5'h00, 5'h00, 0, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h01);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h04);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h10);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h01);
    chk("R3 accumulated word", csr_o, 32'h1515_0000);
    idle();
    chk("R10 closed after four lanes", {31'd0, lane_ready}, 32'd0);

    // new computing start clears cause, keeps sticky
    step(1, 1, 0, 5'h00, 5'h00, 0, 5'h00);
    chk("R2 cause cleared sticky kept", csr_o, 32'h0015_0000);

    // inexact masked (log-base-2 style): nothing lands anywhere
    step(1, 1, 1, 5'h01, 5'h01, 0, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h01);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h01);
    chk("R6 masked inexact ignored", csr_o, 32'h0015_0001);
    chk("R6 no trap from masked flag", {31'd0, trap_o}, 32'd0);

    // trap on final single lane: trap and done together, sticky untouched
    step(1, 1, 0, 5'h00, 5'h08, 0, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h0A);
    chk("R4 trap on last lane word", csr_o, 32'h0A15_0008);
    chk("R8 done with trap", {31'd0, done_o & trap_o}, 32'd1);

    // trap on first lane, further lanes refused
    step(1, 1, 0, 5'h00, 5'h10, 0, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h10);
    snap = csr_o;
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h04);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h04);
    chk("R7 lanes after trap ignored", csr_o, snap);
    chk("R7 trap held", {31'd0, trap_o}, 32'd1);

    // non-computing start has no effect
    step(1, 0, 1, 5'h1F, 5'h1F, 0, 5'h00);
    chk("R9 csr unchanged", csr_o, snap);
    chk("R9 trap unchanged", {31'd0, trap_o}, 32'd1);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h02);
    chk("R9 no lanes opened", csr_o, snap);

    // double precision, trap on second lane
    step(1, 1, 1, 5'h00, 5'h04, 0, 5'h00);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h02);
    step(0, 0, 0, 5'h00, 5'h00, 1, 5'h04);
    chk("R4 double lane trap word", csr_o, 32'h0617_0004);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic       c, d;
      logic [4:0] msk, en;
      c   = ($urandom % 10) != 0;
      d   = $urandom % 2;
      msk = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      en  = ($urandom % 3 == 0) ? (5'd1 << ($urandom % 5)) : 5'd0;
      step(1, c, d, msk, en, $urandom % 2, 5'($urandom));
      for (int k = 0; k < 8; k++) begin
        logic v;
        logic [4:0] f;
        v = ($urandom % 10) < 7;
        f = 5'($urandom) & 5'($urandom);
        if ($urandom % 40 == 0) step(1, 1, $urandom % 2, 5'd0, en, v, f);
        else step(0, 0, 0, 5'd0, 5'd0, v, f);
        if (!m_active && ($urandom % 2 == 0)) break;
      end
    end

    idle();
    finish_run();
  end
endmodule